// File: doc/BRIEF.md
# Controller Memory Buffer Placement Checker

This block sits in the command front end of a storage controller. For each command, it decides whether each address range the command uses lies in the on-controller buffer window or in host memory. It then applies the placement rules. These rules require every part of a command to come wholly from one memory space. They also require list memory to be placed in the window only when the command itself was fetched from a queue in the window. The block reports one pass/fail verdict with a completion status code.

The window is described by a base address and a byte size. The window is dark, meaning every range counts as host memory, unless the following all hold:
- the base sits on a 4 KB boundary;
- the size is nonzero;
- the size fits the backing storage.

A byte-lane write port fills the backing storage. Each beat carries up to one maximum-payload worth of bytes with per-byte enables, at any start alignment. A registered read port returns single bytes.

Top module: `cmb_usage_check`

## Requirements
- R1: The window is enabled only when `winBase[11:0]` is zero, `winSize` is nonzero and `winSize` is at most MEM_BYTES. While it is disabled, every range counts as outside, writes store nothing and reads return 0.
- R2: Each range is absent when its length is 0. Otherwise it is inside when all of its bytes from addr to addr+len-1 lie in [winBase, winBase+winSize). It is outside when none of its bytes do. A range that is partly inside is a violation.
- R3: A submission-queue range that is inside the window is a violation when `supQueue` is 0.
- R4: A list range that is inside the window is a violation when `supList` is 0 or when the submission-queue range is not inside.
- R5: When the data and metadata ranges are both present, one inside and the other outside is a violation. Either one being inside while `supData` is 0 is a violation.
- R6: A `checkStart` pulse with its descriptors yields `checkDone` high for exactly one cycle, two clock edges later. Starts may arrive on back-to-back cycles.
- R7: When `checkDone` is high, `checkStatus` is 8'h12 with `checkPass` low on any violation, and otherwise 8'h00 with `checkPass` high. When `checkDone` is low, both are 0.
- R8: On a `wrValid` beat, lane i writes `wrData[8i+7:8i]` to address `wrAddr+i` when `wrBe[i]` is 1 and that address is inside the window. All other bytes keep their values.
- R9: `rdData` shows, one edge after `rdAddr` is applied, the byte stored at that address, or 0 when the address is outside the window.
- R10: During reset, `checkDone`, `checkPass`, `checkStatus` and `rdData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winBase | input | ADDR_W | Window base address |
| winSize | input | SIZE_W | Window size in bytes |
| supQueue | input | 1 | Queues may be placed in the window |
| supList | input | 1 | PRP/SGL lists may be placed in the window |
| supData | input | 1 | Data and metadata may be placed in the window |
| checkStart | input | 1 | Sample the descriptors below |
| sqAddr | input | ADDR_W | Submission queue start |
| sqLen | input | LEN_W | Submission queue length in bytes |
| listAddr | input | ADDR_W | List start |
| listLen | input | LEN_W | List length, 0 if unused |
| dataAddr | input | ADDR_W | Data start |
| dataLen | input | LEN_W | Data length, 0 if unused |
| metaAddr | input | ADDR_W | Metadata start |
| metaLen | input | LEN_W | Metadata length, 0 if unused |
| checkDone | output | 1 | Verdict valid strobe |
| checkPass | output | 1 | Command placement is legal |
| checkStatus | output | 8 | 8'h00 success, 8'h12 invalid buffer use |
| wrValid | input | 1 | Write beat present |
| wrAddr | input | ADDR_W | Address of lane 0 |
| wrData | input | 8*MPS_BYTES | Beat bytes, lane i at bits 8i+7:8i |
| wrBe | input | MPS_BYTES | Per-lane byte enables |
| rdAddr | input | ADDR_W | Byte read address |
| rdData | output | 8 | Registered read byte |

## Verification
The assertions check the following on every cycle:
- the two-edge start-to-done timing;
- that the status and pass outputs are consistent with each other and quiet between verdicts;
- that reads return zero for a misaligned base or for an address below the window.

Only the bench's scenarios can show the following:
- that the verdict is correct for each combination of range positions and support flags;
- that a straddling range fails;
- that byte-lane writes at every alignment land on the right offsets and leave neighbouring bytes intact.

// File: rtl/cmb_pkg.sv
`timescale 1ns/1ps
package cmb_pkg;
  localparam int NUM_RANGES = 4;
  localparam int IDX_SQ     = 0;
  localparam int IDX_LIST   = 1;
  localparam int IDX_DATA   = 2;
  localparam int IDX_META   = 3;

  localparam logic [7:0] STATUS_OK      = 8'h00;
  localparam logic [7:0] STATUS_BAD_CMB = 8'h12;

  typedef enum logic [1:0] {
    RC_ABSENT = 2'd0,
    RC_IN     = 2'd1,
    RC_OUT    = 2'd2,
    RC_SPLIT  = 2'd3
  } rangeClass_t;

  typedef struct packed {
    logic capture;
    logic finish;
  } ctrlStrobe_t;
endpackage

// File: rtl/cmb_range_class.sv
`timescale 1ns/1ps
module cmb_range_class
  import cmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              winOn,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W:0]   winEnd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output rangeClass_t       cls
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] startX;
  logic [EXT_W-1:0] lastX;
  logic [EXT_W-1:0] baseX;
  logic             fullyIn;
  logic             touches;

  assign startX  = {1'b0, addr};
  assign baseX   = {1'b0, winBase};
  assign lastX   = startX + EXT_W'(len) - EXT_W'(1);
  assign fullyIn = winOn && (startX >= baseX) && (lastX < winEnd);
  assign touches = winOn && (startX < winEnd) && (lastX >= baseX);

  always_comb begin
    if (len == '0)       cls = RC_ABSENT;
    else if (fullyIn)    cls = RC_IN;
    else if (touches)    cls = RC_SPLIT;
    else                 cls = RC_OUT;
  end
endmodule

// File: rtl/cmb_ctrl.sv
`timescale 1ns/1ps
module cmb_ctrl
  import cmb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        checkStart,
  output ctrlStrobe_t strb
);
  logic stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) stageValid <= 1'b0;
    else       stageValid <= checkStart;
  end

  always_comb begin
    strb.capture = checkStart;
    strb.finish  = stageValid;
  end
endmodule

// File: rtl/cmb_datapath.sv
`timescale 1ns/1ps
module cmb_datapath
  import cmb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 10,
  parameter int LEN_W      = 8,
  parameter int MEM_BYTES  = 256,
  parameter int MPS_BYTES  = 8,
  parameter int ALIGN_BITS = 12
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ctrlStrobe_t                           strb,
  input  logic [ADDR_W-1:0]                     winBase,
  input  logic [SIZE_W-1:0]                     winSize,
  input  logic                                  supQueue,
  input  logic                                  supList,
  input  logic                                  supData,
  input  logic [NUM_RANGES-1:0][ADDR_W-1:0]     rangeAddr,
  input  logic [NUM_RANGES-1:0][LEN_W-1:0]      rangeLen,
  output logic                                  checkDone,
  output logic                                  checkPass,
  output logic [7:0]                            checkStatus,
  input  logic                                  wrValid,
  input  logic [ADDR_W-1:0]                     wrAddr,
  input  logic [8*MPS_BYTES-1:0]                wrData,
  input  logic [MPS_BYTES-1:0]                  wrBe,
  input  logic [ADDR_W-1:0]                     rdAddr,
  output logic [7:0]                            rdData
);
  localparam int EXT_W     = ADDR_W + 1;
  localparam int MEM_IDX_W = $clog2(MEM_BYTES);

  // window decode
  logic             winOn;
  logic [EXT_W-1:0] winEnd;
  logic [EXT_W-1:0] baseX;

  assign baseX  = {1'b0, winBase};
  assign winEnd = baseX + EXT_W'(winSize);
  assign winOn  = (winBase[ALIGN_BITS-1:0] == '0) && (winSize != '0) &&
                  (winSize <= SIZE_W'(MEM_BYTES));

  // descriptor capture
  logic [NUM_RANGES-1:0][ADDR_W-1:0] addrQ;
  logic [NUM_RANGES-1:0][LEN_W-1:0]  lenQ;
  logic                              supQueueQ, supListQ, supDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      lenQ      <= '0;
      supQueueQ <= 1'b0;
      supListQ  <= 1'b0;
      supDataQ  <= 1'b0;
    end else if (strb.capture) begin
      addrQ     <= rangeAddr;
      lenQ      <= rangeLen;
      supQueueQ <= supQueue;
      supListQ  <= supList;
      supDataQ  <= supData;
    end
  end

  // per-range classification
  rangeClass_t cls [NUM_RANGES];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cls
    cmb_range_class #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cls (
      .winOn  (winOn),
      .winBase(winBase),
      .winEnd (winEnd),
      .addr   (addrQ[g]),
      .len    (lenQ[g]),
      .cls    (cls[g])
    );
  end

  // placement rules
  logic anySplit;
  logic sqIn, listIn, dataIn, metaIn, dataOut, metaOut;
  logic badQueue, badList, badData, badMix, violation;

  always_comb begin
    anySplit = 1'b0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (cls[i] == RC_SPLIT) anySplit = 1'b1;
    end
  end

  assign sqIn      = (cls[IDX_SQ]   == RC_IN);
  assign listIn    = (cls[IDX_LIST] == RC_IN);
  assign dataIn    = (cls[IDX_DATA] == RC_IN);
  assign metaIn    = (cls[IDX_META] == RC_IN);
  assign dataOut   = (cls[IDX_DATA] == RC_OUT);
  assign metaOut   = (cls[IDX_META] == RC_OUT);
  assign badQueue  = sqIn && !supQueueQ;
  assign badList   = listIn && (!supListQ || !sqIn);
  assign badData   = (dataIn || metaIn) && !supDataQ;
  assign badMix    = (dataIn && metaOut) || (dataOut && metaIn);
  assign violation = anySplit || badQueue || badList || badData || badMix;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      checkDone   <= 1'b0;
      checkPass   <= 1'b0;
      checkStatus <= STATUS_OK;
    end else begin
      checkDone   <= strb.finish;
      checkPass   <= strb.finish && !violation;
      checkStatus <= (strb.finish && violation) ? STATUS_BAD_CMB : STATUS_OK;
    end
  end

  // backing storage, byte lanes at any alignment
  logic [7:0]           mem [MEM_BYTES];
  logic [MPS_BYTES-1:0] laneHit;
  logic [MEM_IDX_W-1:0] laneIdx [MPS_BYTES];

  for (genvar l = 0; l < MPS_BYTES; l++) begin : g_lane
    logic [EXT_W-1:0] laneAddr;
    assign laneAddr   = {1'b0, wrAddr} + EXT_W'(l);
    assign laneHit[l] = wrValid && winOn && wrBe[l] &&
                        (laneAddr >= baseX) && (laneAddr < winEnd);
    assign laneIdx[l] = wrAddr[MEM_IDX_W-1:0] - winBase[MEM_IDX_W-1:0] +
                        MEM_IDX_W'(l);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MPS_BYTES; i++) begin
      if (laneHit[i]) mem[laneIdx[i]] <= wrData[8*i +: 8];
    end
  end

  logic                 rdHit;
  logic [MEM_IDX_W-1:0] rdIdx;

  assign rdHit = winOn && ({1'b0, rdAddr} >= baseX) && ({1'b0, rdAddr} < winEnd);
  assign rdIdx = rdAddr[MEM_IDX_W-1:0] - winBase[MEM_IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)      rdData <= 8'h00;
    else if (rdHit) rdData <= mem[rdIdx];
    else            rdData <= 8'h00;
  end
endmodule

// File: rtl/cmb_usage_check.sv
`timescale 1ns/1ps
module cmb_usage_check
  import cmb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 10,
  parameter int LEN_W      = 8,
  parameter int MEM_BYTES  = 256,
  parameter int MPS_BYTES  = 8,
  parameter int ALIGN_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      winBase,
  input  logic [SIZE_W-1:0]      winSize,
  input  logic                   supQueue,
  input  logic                   supList,
  input  logic                   supData,
  input  logic                   checkStart,
  input  logic [ADDR_W-1:0]      sqAddr,
  input  logic [LEN_W-1:0]       sqLen,
  input  logic [ADDR_W-1:0]      listAddr,
  input  logic [LEN_W-1:0]       listLen,
  input  logic [ADDR_W-1:0]      dataAddr,
  input  logic [LEN_W-1:0]       dataLen,
  input  logic [ADDR_W-1:0]      metaAddr,
  input  logic [LEN_W-1:0]       metaLen,
  output logic                   checkDone,
  output logic                   checkPass,
  output logic [7:0]             checkStatus,
  input  logic                   wrValid,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [8*MPS_BYTES-1:0] wrData,
  input  logic [MPS_BYTES-1:0]   wrBe,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [7:0]             rdData
);
  ctrlStrobe_t                       strb;
  logic [NUM_RANGES-1:0][ADDR_W-1:0] rangeAddr;
  logic [NUM_RANGES-1:0][LEN_W-1:0]  rangeLen;

  always_comb begin
    rangeAddr[IDX_SQ]   = sqAddr;
    rangeAddr[IDX_LIST] = listAddr;
    rangeAddr[IDX_DATA] = dataAddr;
    rangeAddr[IDX_META] = metaAddr;
    rangeLen[IDX_SQ]    = sqLen;
    rangeLen[IDX_LIST]  = listLen;
    rangeLen[IDX_DATA]  = dataLen;
    rangeLen[IDX_META]  = metaLen;
  end

  cmb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .checkStart(checkStart),
    .strb      (strb)
  );

  cmb_datapath #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W),
    .MEM_BYTES(MEM_BYTES), .MPS_BYTES(MPS_BYTES), .ALIGN_BITS(ALIGN_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .winBase    (winBase),
    .winSize    (winSize),
    .supQueue   (supQueue),
    .supList    (supList),
    .supData    (supData),
    .rangeAddr  (rangeAddr),
    .rangeLen   (rangeLen),
    .checkDone  (checkDone),
    .checkPass  (checkPass),
    .checkStatus(checkStatus),
    .wrValid    (wrValid),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .wrBe       (wrBe),
    .rdAddr     (rdAddr),
    .rdData     (rdData)
  );
endmodule

// File: rtl/cmb_usage_check_sva.sv
`timescale 1ns/1ps
module cmb_usage_check_sva #(
  parameter int ADDR_W     = 16,
  parameter int ALIGN_BITS = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              checkStart,
  input logic              checkDone,
  input logic              checkPass,
  input logic [7:0]        checkStatus,
  input logic [ADDR_W-1:0] winBase,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData
);
  a_r6_done_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $past(checkStart, 2) |-> checkDone);

  a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (!rstN)
    !$past(checkStart, 2) |-> !checkDone);

  a_r7_status_pairing: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |-> ((checkStatus == 8'h00) && checkPass) ||
                  ((checkStatus == 8'h12) && !checkPass));

  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !checkDone |-> (checkStatus == 8'h00) && !checkPass);

  a_r1_dark_read: assert property (@(posedge clk) disable iff (!rstN)
    $past(winBase[ALIGN_BITS-1:0] != '0) |-> (rdData == 8'h00));

  a_r9_below_window_read: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdAddr < winBase) |-> (rdData == 8'h00));
endmodule

bind cmb_usage_check cmb_usage_check_sva #(
  .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)
) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .checkStart (checkStart),
  .checkDone  (checkDone),
  .checkPass  (checkPass),
  .checkStatus(checkStatus),
  .winBase    (winBase),
  .rdAddr     (rdAddr),
  .rdData     (rdData)
);

// File: tb/cmb_usage_check_test.sv
`timescale 1ns/1ps
module cmb_usage_check_test;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 10;
  localparam int LEN_W  = 8;
  localparam int MEMB   = 256;
  localparam int MPS    = 8;
  localparam int WIN    = 64;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [ADDR_W-1:0]  winBase = '0;
  logic [SIZE_W-1:0]  winSize = '0;
  logic               supQueue = 0, supList = 0, supData = 0;
  logic               checkStart = 0;
  logic [ADDR_W-1:0]  sqAddr = '0, listAddr = '0, dataAddr = '0, metaAddr = '0;
  logic [LEN_W-1:0]   sqLen = '0, listLen = '0, dataLen = '0, metaLen = '0;
  logic               checkDone, checkPass;
  logic [7:0]         checkStatus;
  logic               wrValid = 0;
  logic [ADDR_W-1:0]  wrAddr = '0;
  logic [8*MPS-1:0]   wrData = '0;
  logic [MPS-1:0]     wrBe = '0;
  logic [ADDR_W-1:0]  rdAddr = '0;
  logic [7:0]         rdData;

  int nVec = 0;
  int nBad = 0;
  logic [7:0] shadow [WIN];

  always #5 clk = ~clk;

  cmb_usage_check uut (
    .clk(clk), .rstN(rstN), .winBase(winBase), .winSize(winSize),
    .supQueue(supQueue), .supList(supList), .supData(supData),
    .checkStart(checkStart),
    .sqAddr(sqAddr), .sqLen(sqLen), .listAddr(listAddr), .listLen(listLen),
    .dataAddr(dataAddr), .dataLen(dataLen), .metaAddr(metaAddr), .metaLen(metaLen),
    .checkDone(checkDone), .checkPass(checkPass), .checkStatus(checkStatus),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic bit winEnabled(int b, int s);
    return ((b % 4096) == 0) && (s > 0) && (s <= MEMB);
  endfunction

  // 0 absent, 1 inside, 2 outside, 3 straddle
  function automatic int classOf(int b, int s, int a, int l);
    int e;
    if (l == 0) return 0;
    if (!winEnabled(b, s)) return 2;
    e = a + l - 1;
    if (a >= b && e < b + s) return 1;
    if (a < b + s && e >= b) return 3;
    return 2;
  endfunction

  function automatic int posAddr(int p, int b, int s);
    case (p)
      1: return b - 16;
      2: return b + 4;
      3: return b + s - 4;
      4: return b + s + 8;
      5: return b - 4;
      default: return b;
    endcase
  endfunction

  function automatic int posLen(int p);
    return (p == 0) ? 0 : 8;
  endfunction

  function automatic bit expectFail(int b, int s, int sa, int sl, int la, int ll,
                                    int da, int dl, int ma, int ml,
                                    bit fq, bit fl, bit fd);
    int cs, cl, cd, cm;
    cs = classOf(b, s, sa, sl);
    cl = classOf(b, s, la, ll);
    cd = classOf(b, s, da, dl);
    cm = classOf(b, s, ma, ml);
    if (cs == 3 || cl == 3 || cd == 3 || cm == 3) return 1;   // R2
    if (cs == 1 && !fq) return 1;                              // R3
    if (cl == 1 && (!fl || cs != 1)) return 1;                 // R4
    if ((cd == 1 || cm == 1) && !fd) return 1;                 // R5
    if ((cd == 1 && cm == 2) || (cd == 2 && cm == 1)) return 1; // R5
    return 0;
  endfunction

  task automatic checkVerdict(string tag, bit expFail);
    logic [7:0] expStatus;
    expStatus = expFail ? 8'h12 : 8'h00;
    nVec++;
    if (checkDone !== 1'b1 || checkStatus !== expStatus || checkPass !== !expFail) begin
      nBad++;
      $display("FAIL %s: done=%0b status=%02h pass=%0b expected done=1 status=%02h pass=%0b",
               tag, checkDone, checkStatus, checkPass, expStatus, !expFail);
    end
  endtask

  task automatic loadDesc(int sa, int sl, int la, int ll, int da, int dl,
                          int ma, int ml, bit fq, bit fl, bit fd);
    sqAddr   = ADDR_W'(sa); sqLen   = LEN_W'(sl);
    listAddr = ADDR_W'(la); listLen = LEN_W'(ll);
    dataAddr = ADDR_W'(da); dataLen = LEN_W'(dl);
    metaAddr = ADDR_W'(ma); metaLen = LEN_W'(ml);
    supQueue = fq; supList = fl; supData = fd;
  endtask

  task automatic writeBeat(int a, logic [8*MPS-1:0] d, logic [MPS-1:0] be);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = ADDR_W'(a); wrData = d; wrBe = be;
    @(negedge clk);
    wrValid = 1'b0; wrBe = '0;
  endtask

  task automatic readCheck(string tag, int a, logic [7:0] expv);
    @(negedge clk);
    rdAddr = ADDR_W'(a);
    @(negedge clk);
    nVec++;
    if (rdData !== expv) begin
      nBad++;
      $display("FAIL %s: addr=%04h rdData=%02h expected=%02h", tag, a, rdData, expv);
    end
  endtask

  task automatic readAllShadow(string tag, int b);
    for (int i = 0; i < WIN; i++) readCheck(tag, b + i, shadow[i]);
  endtask

  // placement sweep over one configuration
  task automatic sweepConfig(int b, int s);
    @(negedge clk);
    winBase = ADDR_W'(b); winSize = SIZE_W'(s);
    for (int ps = 0; ps < 6; ps++)
      for (int pl = 0; pl < 6; pl++)
        for (int pd = 0; pd < 6; pd++)
          for (int pm = 0; pm < 6; pm++)
            for (int f = 0; f < 8; f++) begin
              int sa, la, da, ma;
              bit ef;
              sa = posAddr(ps, b, s); la = posAddr(pl, b, s);
              da = posAddr(pd, b, s); ma = posAddr(pm, b, s);
              ef = expectFail(b, s, sa, posLen(ps), la, posLen(pl), da, posLen(pd),
                              ma, posLen(pm), f[0], f[1], f[2]);
              @(negedge clk);
              loadDesc(sa, posLen(ps), la, posLen(pl), da, posLen(pd), ma, posLen(pm),
                       f[0], f[1], f[2]);
              checkStart = 1'b1;
              @(negedge clk);
              checkStart = 1'b0;
              @(negedge clk);
              checkVerdict("R2/R3/R4/R5/R7 sweep", ef);
            end
  endtask

  initial begin : watchdog
    #1900000;
    nBad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin : main
    int b;
    b = 32'h1000;

    // R10: reset values
    repeat (3) @(negedge clk);
    nVec++;
    if (checkDone !== 1'b0 || checkPass !== 1'b0 || checkStatus !== 8'h00 || rdData !== 8'h00) begin
      nBad++;
      $display("FAIL R10: done=%0b pass=%0b status=%02h rd=%02h expected all 0",
               checkDone, checkPass, checkStatus, rdData);
    end
    rstN = 1'b1;

    // R6: done exactly one cycle, two edges after start, then low
    @(negedge clk);
    winBase = ADDR_W'(b); winSize = SIZE_W'(WIN);
    loadDesc(b + 4, 8, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    checkStart = 1'b1;
    @(negedge clk);
    checkStart = 1'b0;
    nVec++;
    if (checkDone !== 1'b0) begin
      nBad++; $display("FAIL R6: early done=%0b expected 0", checkDone);
    end
    @(negedge clk);
    checkVerdict("R6 single start", 0);
    @(negedge clk);
    nVec++;
    if (checkDone !== 1'b0) begin
      nBad++; $display("FAIL R6: done held=%0b expected 0", checkDone);
    end

    // R6: back-to-back starts with different verdicts
    @(negedge clk);
    loadDesc(b + 4, 8, b + 20, 8, 0, 0, 0, 0, 1, 0, 1);   // list in, no list support
    checkStart = 1'b1;
    @(negedge clk);
    loadDesc(b + 4, 8, b + 20, 8, 0, 0, 0, 0, 1, 1, 1);   // legal
    @(negedge clk);
    checkStart = 1'b0;
    checkVerdict("R6 back-to-back first (R4)", 1);
    @(negedge clk);
    checkVerdict("R6 back-to-back second", 0);

    // R4: list inside with queue in host memory
    @(negedge clk);
    loadDesc(b - 64, 8, b + 20, 8, 0, 0, 0, 0, 1, 1, 1);
    checkStart = 1'b1;
    @(negedge clk);
    checkStart = 1'b0;
    @(negedge clk);
    checkVerdict("R4 list in, queue out", 1);

    // R2/R3/R4/R5/R7 sweeps: enabled, misaligned (R1), oversized (R1)
    sweepConfig(32'h1000, WIN);
    sweepConfig(32'h1800, WIN);
    sweepConfig(32'h2000, 300);

    // R8/R9: storage writes at every alignment
    @(negedge clk);
    winBase = ADDR_W'(b); winSize = SIZE_W'(WIN);
    for (int i = 0; i < WIN; i += MPS) writeBeat(b + i, '0, '1);
    for (int i = 0; i < WIN; i++) shadow[i] = 8'h00;
    readAllShadow("R9 zero fill", b);
    for (int st = -MPS; st < WIN; st++) begin
      logic [8*MPS-1:0] d;
      logic [MPS-1:0]   be;
      for (int l = 0; l < MPS; l++) d[8*l +: 8] = 8'((st + 100) * 7 + l * 13);
      be = MPS'((st * 37 + 91) % 256) | MPS'(1);
      writeBeat(b + st, d, be);
      for (int l = 0; l < MPS; l++) begin
        int off;
        off = st + l;
        if (be[l] && off >= 0 && off < WIN) shadow[off] = d[8*l +: 8];
      end
      readAllShadow("R8 lane write", b);
    end
    // R9: outside addresses read as zero
    readCheck("R9 below window", b - 1, 8'h00);
    readCheck("R9 above window", b + WIN, 8'h00);

    // R1: disabled window stores nothing and reads zero
    @(negedge clk);
    winBase = ADDR_W'(b + 4);
    writeBeat(b + 4, {MPS{8'hEE}}, '1);
    readCheck("R1 dark read", b + 4, 8'h00);
    @(negedge clk);
    winBase = ADDR_W'(b);
    readAllShadow("R1 dark write dropped", b);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule